// File: doc/BRIEF.md
# TDM Frame Receiver with Holding Register

This block is the receive end of a 32-slot time-division-multiplexed serial link. It runs on the bit clock and takes one serial data bit per cycle along with a frame marker. A free-running 8-bit position counter tracks where in the 256-bit frame each bit belongs. The upper five counter bits name the slot and the lower three name the bit within the slot. When the frame marker is seen, the counter is forced to zero on that edge, which keeps it in step with the sender's counter as that counter wraps.

Incoming bits enter a serial-in, parallel-out register, most significant bit first. On the edge that carries the last bit of a slot, the completed byte, including that final bit, is copied into a holding register. The holding register then keeps the byte steady while the next slot shifts in. Along with the byte, the block presents the slot number the byte came from and a one-cycle strobe marking each update. No strobe is issued until the first frame marker after reset, because before then the slot boundaries are unknown.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `rx_byte` and `rx_slot` are 0 and `rx_valid` is 0.
- R2: An edge with `frame_mark` high loads the position counter with 0, so the next bit received is bit 0 of slot 0. The first byte delivered after a marker carries `rx_slot` = 0.
- R3: Bits enter most significant first. The delivered byte has the earliest received bit of the slot in bit 7 and the bit sampled on the completing edge in bit 0.
- R4: A transfer happens on the edge whose counter low three bits equal 7. `rx_valid` is high for exactly the cycle after that edge, and `rx_slot` equals the counter's upper five bits at that edge.
- R5: Between transfers `rx_byte` and `rx_slot` do not change while the following eight bits arrive.
- R6: From reset until the first edge with `frame_mark` high, `rx_valid` stays 0. That first marker edge itself produces no transfer.
- R7: A marker that arrives, after alignment, on the edge where the counter is 255 still delivers the byte of slot 31.
- R8: A marker that arrives when the counter is not 255 forces the counter to 0 and produces no transfer, even if the low three bits equal 7.
- R9: Without a marker the counter wraps from 255 to 0, and the byte after slot 31 is delivered with `rx_slot` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| frame_mark | input | 1 | Frame marker, high during the last bit of a frame |
| rx_byte | output | 8 | Holding-register byte |
| rx_slot | output | 5 | Slot number of the byte in the holding register |
| rx_valid | output | 1 | One-cycle strobe on each holding-register update |

## Verification
The bench feeds bits before any marker and checks that no byte is delivered, since a receiver that strobes while unaligned would hand out misframed bytes. It places markers at count 255, which must still deliver slot 31, and at a mid-slot position and a bit-7 position other than 255, where a design that checks only the low bits would deliver a half-formed byte. It also lets the counter wrap with no marker, which catches a design that stalls or mislabels slot 0. On every bit it checks that the holding register stays steady and that the strobe lasts one cycle, which catches a design that exposes the live shift register or reports the slot currently arriving.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  // Default link geometry: slots per frame and bits per slot (powers of two)
  localparam int DEF_SLOTS     = 32;
  localparam int DEF_SLOT_BITS = 8;

  function automatic int log2c(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/tdm_rx_counter.sv
module tdm_rx_counter
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS     = DEF_SLOTS,
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  localparam int BW = log2c(SLOT_BITS),
  localparam int CW = log2c(SLOTS * SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark,
  output logic [CW-1:0] pos,
  output logic          locked,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      locked <= 1'b0;
    end else if (mark) begin
      pos    <= '0;
      locked <= 1'b1;
    end else begin
      pos    <= pos + 1'b1;
    end
  end

  // A slot completes on its last bit; a marker only counts on the frame's last bit
  always_comb begin
    done = locked && (&pos[BW-1:0]) && (!mark || (&pos));
  end

  assert_mark_zero_R2: assert property (@(posedge clk) disable iff (rst)
    mark |=> (pos == '0));
  assert_free_run_R9: assert property (@(posedge clk) disable iff (rst)
    !mark |=> (pos == CW'($past(pos) + 1'b1)));
  assert_no_midslot_R8: assert property (@(posedge clk) disable iff (rst)
    (mark && !(&pos)) |-> !done);
endmodule

// File: rtl/tdm_rx_shifter.sv
module tdm_rx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] word_next
);
  logic [W-1:0] sh;

  always_comb word_next = {sh[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= word_next;
  end

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sh[0] == $past(bit_in)));
endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold #(
  parameter int W  = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  word,
  input  logic [SW-1:0] slot,
  output logic [W-1:0]  hold_byte,
  output logic [SW-1:0] hold_slot,
  output logic          hold_valid
);
  logic rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte  <= '0;
      hold_slot  <= '0;
      hold_valid <= 1'b0;
    end else begin
      hold_valid <= load;
      if (load) begin
        hold_byte <= word;
        hold_slot <= slot;
      end
    end
  end

  always_ff @(posedge clk) rst_q <= rst;

  assert_pulse_once_R4: assert property (@(posedge clk) disable iff (rst)
    hold_valid |=> !hold_valid);
  assert_hold_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold_valid && !rst_q) |-> ($stable(hold_byte) && $stable(hold_slot)));
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS     = DEF_SLOTS,
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  localparam int BW = log2c(SLOT_BITS),
  localparam int SW = log2c(SLOTS),
  localparam int CW = BW + SW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_in,
  input  logic                 frame_mark,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic [SW-1:0]        rx_slot,
  output logic                 rx_valid
);
  logic [CW-1:0]        pos;
  logic                 locked;
  logic                 done;
  logic [SLOT_BITS-1:0] word_next;

  tdm_rx_counter #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_cnt (
    .clk(clk), .rst(rst), .mark(frame_mark),
    .pos(pos), .locked(locked), .done(done)
  );

  tdm_rx_shifter #(.W(SLOT_BITS)) u_sh (
    .clk(clk), .rst(rst), .bit_in(ser_in), .word_next(word_next)
  );

  tdm_rx_hold #(.W(SLOT_BITS), .SW(SW)) u_hold (
    .clk(clk), .rst(rst), .load(done), .word(word_next),
    .slot(pos[CW-1:BW]),
    .hold_byte(rx_byte), .hold_slot(rx_slot), .hold_valid(rx_valid)
  );

  assert_unlocked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !rx_valid);
  assert_frame_end_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_mark && locked && (&pos)) |=> (rx_valid && rx_slot == SW'(SLOTS-1)));
endmodule

// File: tb/tdm_frame_rx_test.sv
module tdm_frame_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       frame_mark = 1'b0;
  logic [7:0] rx_byte;
  logic [4:0] rx_slot;
  logic       rx_valid;

  int checks = 0;
  int fails  = 0;

  // model state (from the requirements)
  int         m_pos = 0;
  bit         m_lock = 0;
  logic [7:0] m_sh = 8'h00;
  logic [7:0] m_byte = 8'h00;
  logic [4:0] m_slot = 5'd0;
  int         pulses = 0;

  localparam logic [7:0] PAT [16] = '{
    8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'h01, 8'h80,
    8'h55, 8'hAA, 8'hC3, 8'h96, 8'h0F, 8'hF0, 8'h69, 8'h12};

  tdm_frame_rx uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .frame_mark(frame_mark),
    .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bit (with marker), wait through the edge, check at the next falling edge
  task automatic send_bit(input logic b, input logic mk);
    bit   xfer;
    bit   was_lock;
    string tag;
    ser_in = b;
    frame_mark = mk;
    was_lock = m_lock;
    xfer = m_lock && (m_pos % 8 == 7) && (!mk || m_pos == 255);
    m_sh = {m_sh[6:0], b};
    if (xfer) begin
      m_byte = m_sh;
      m_slot = 5'(m_pos / 8);
    end
    m_pos = mk ? 0 : (m_pos + 1) % 256;
    if (mk) m_lock = 1;
    @(negedge clk);
    if (rx_valid) pulses++;
    if (xfer)          tag = mk ? "R7" : "R4";
    else if (!was_lock) tag = "R6";
    else if (mk)       tag = "R8";
    else               tag = "R5";
    check(rx_valid == xfer, tag, int'(rx_valid), int'(xfer));
    check(rx_byte == m_byte, xfer ? "R3" : tag, int'(rx_byte), int'(m_byte));
    check(rx_slot == m_slot, xfer ? "R4" : tag, int'(rx_slot), int'(m_slot));
    frame_mark = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic mark_last);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? mark_last : 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    check(rx_valid == 0 && rx_byte == 0 && rx_slot == 0, "R1",
          {rx_valid, rx_byte, rx_slot}, 0);
    @(negedge clk);
    rst = 1'b0;
    m_pos = 0; m_lock = 0; m_sh = 0; m_byte = 0; m_slot = 0;
    @(negedge clk);
    m_sh = {m_sh[6:0], ser_in};
    m_pos = 1;
    check(rx_valid == 0 && rx_byte == 0 && rx_slot == 0, "R1",
          {rx_valid, rx_byte, rx_slot}, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R6: traffic before any marker must not strobe
    pulses = 0;
    for (int i = 0; i < 40; i++) send_bit(1'(i % 3), 1'b0);
    check(pulses == 0, "R6", pulses, 0);

    // First marker at a mid-frame position: aligns, no transfer (R6, R8)
    send_bit(1'b1, 1'b1);

    // Table walk: two full frames; first ends with a marker, second wraps
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 32; s++) begin
        send_byte(PAT[s % 16] ^ 8'(s), (f == 0 && s == 31));
        check(rx_slot == 5'(s), (s == 0) ? "R2" : "R4", int'(rx_slot), s);
      end
    end
    // R9: wrap without marker gives slot 0 next
    send_byte(8'hC9, 1'b0);
    check(rx_slot == 0 && rx_byte == 8'hC9, "R9", {rx_slot, rx_byte}, 8'hC9);

    // R8: marker in the middle of slot 1
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    send_byte(8'h5A, 1'b0);
    check(rx_slot == 0 && rx_byte == 8'h5A, "R2", {rx_slot, rx_byte}, 8'h5A);

    // R8: marker on bit 7 of a slot other than the last
    pulses = 0;
    send_byte(8'hE7, 1'b1);
    check(pulses == 0 && rx_byte == 8'h5A, "R8", rx_byte, 8'h5A);
    send_byte(8'h3D, 1'b0);
    check(rx_slot == 0 && rx_byte == 8'h3D, "R2", {rx_slot, rx_byte}, 8'h3D);

    // R1/R6: reset mid-stream, then unlocked again
    do_reset();
    pulses = 0;
    for (int i = 0; i < 16; i++) send_bit(1'b1, 1'b0);
    check(pulses == 0, "R6", pulses, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule